// File: doc/BRIEF.md
# Machine-Cycle Status Decoder

This block sits beside an 8-bit processor that puts a status byte on its data bus at the start of each machine cycle. It keeps that byte in a register when the processor's sync output is high. For the rest of the cycle it combines the stored bits with the processor's active-high read strobe and active-low write strobe. From these it produces separate active-high strobes for memory read, memory write, port read, port write and interrupt acknowledge. It also provides level indicators for halt, stack access and opcode fetch.

Board logic uses these strobes in place of address-mapped chip selects. Memory and ports then occupy separate spaces, and the interrupt controller can recognise the acknowledge fetch. While the processor grants its bus away (hold acknowledge), the five strobes stay low so that another bus master can drive memory and ports.

Top module: `bus_status_decoder`

## Requirements
- R1: The status register loads the data bus on each rising clock edge at which `sync` is high, and it keeps that value through every later edge at which `sync` is low.
- R2: After a synchronous active-low reset, all eight outputs stay low until the first `sync` has been captured, whatever the read and write strobes do.
- R3: `mem_rd` is high when `dbin` is high and captured status bit 7 is set.
- R4: `io_rd` is high when `dbin` is high and captured status bit 6 is set.
- R5: `int_ack` is high when `dbin` is high and captured status bit 0 is set.
- R6: `io_wr` is high when `wr_n` is low, captured bit 1 is clear and captured bit 4 is set.
- R7: `mem_wr` is high when `wr_n` is low, captured bit 1 is clear and captured bit 4 is clear.
- R8: While `hlda` is high, none of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` or `int_ack` is asserted.
- R9: `halted`, `stack_acc` and `op_fetch` follow captured status bits 3, 2 and 5. They do not depend on the strobes or on `hlda`.
- R10: Data-bus changes while `sync` is low have no effect on any output.
- R11: A low `wr_n` produces no write strobe when captured status bit 1 is set, which marks a read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-synchronous clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_bus | input | 8 | Processor data bus; carries the status byte during sync |
| sync | input | 1 | High while the status byte is on the data bus |
| dbin | input | 1 | Active-high read strobe |
| wr_n | input | 1 | Active-low write strobe |
| hlda | input | 1 | Hold acknowledge; the processor has released the buses |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| int_ack | output | 1 | Interrupt acknowledge strobe |
| halted | output | 1 | Processor is halted |
| stack_acc | output | 1 | Current cycle addresses the stack |
| op_fetch | output | 1 | Current cycle fetches an opcode's first byte |

## Verification
The bench builds the block with its default 8-bit status width, so each status flag has its own bus line. The bench can therefore set any combination of flags, including combinations a real processor never issues, such as write cycles with the read bit set. It drives junk onto the bus between sync pulses to show that the register ignores it. It also raises both strobes right after reset to show that outputs stay quiet until the first capture.

// File: rtl/bsd_pkg.sv
// Package: bit positions of the machine-cycle status byte and the strobe
// bundle shared by the decoder modules.
// Assumes: the processor's status byte is at least 8 bits wide.
package bsd_pkg;
    localparam int STAT_W  = 8;
    // Positions fixed by the processor's status encoding.
    localparam int B_INTA  = 0;
    localparam int B_RDCYC = 1;
    localparam int B_STACK = 2;
    localparam int B_HALT  = 3;
    localparam int B_OUTP  = 4;
    localparam int B_FETCH = 5;
    localparam int B_INP   = 6;
    localparam int B_MEM   = 7;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic int_ack;
    } strobe_t;

    typedef struct packed {
        logic halted;
        logic stack_acc;
        logic op_fetch;
    } indic_t;
endpackage

// File: rtl/bsd_status_capture.sv
// Module: holds the status byte sampled while sync is high and raises a
// valid flag once the first status byte has been taken after reset.
// Assumes: sync is synchronous to clk; reset is synchronous, active low.
module bsd_status_capture #(
    parameter int STAT_W = bsd_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] bus_in,
    input  logic              sync,
    output logic [STAT_W-1:0] status_q,
    output logic              valid_q
);
    // Status register: loads on sync, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (sync)
            status_q <= bus_in;
    end

    // Valid flag: set by the first sync after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else if (sync)
            valid_q <= 1'b1;
    end
endmodule

// File: rtl/bsd_strobe_decode.sv
// Module: combines the held status with the read/write strobes and hold
// acknowledge into separate bus strobes and status indicators.
// Assumes: status_i is stable for the whole machine cycle; wr_n_i is
// active low and rd_i active high.
module bsd_strobe_decode #(
    parameter int STAT_W = bsd_pkg::STAT_W
) (
    input  logic              [STAT_W-1:0] status_i,
    input  logic                           valid_i,
    input  logic                           rd_i,
    input  logic                           wr_n_i,
    input  logic                           hold_i,
    output bsd_pkg::strobe_t               strobe_o,
    output bsd_pkg::indic_t                indic_o
);
    import bsd_pkg::*;

    logic rd_ok, wr_ok;

    // Qualify the raw strobes with the capture flag, hold and cycle type.
    always_comb begin
        rd_ok = valid_i && !hold_i && rd_i;
        wr_ok = valid_i && !hold_i && !wr_n_i && !status_i[B_RDCYC];
    end

    // Strobe decode from the held status bits.
    always_comb begin
        strobe_o.mem_rd  = rd_ok && status_i[B_MEM];
        strobe_o.io_rd   = rd_ok && status_i[B_INP];
        strobe_o.int_ack = rd_ok && status_i[B_INTA];
        strobe_o.io_wr   = wr_ok && status_i[B_OUTP];
        strobe_o.mem_wr  = wr_ok && !status_i[B_OUTP];
    end

    // Level indicators, independent of strobes and hold.
    always_comb begin
        indic_o.halted    = valid_i && status_i[B_HALT];
        indic_o.stack_acc = valid_i && status_i[B_STACK];
        indic_o.op_fetch  = valid_i && status_i[B_FETCH];
    end
endmodule

// File: rtl/bus_status_decoder.sv
// Module: top of the status decoder; captures the status byte on sync and
// drives decoded memory, port and interrupt-acknowledge strobes.
// Assumes: one status byte per machine cycle, presented with sync high
// for at least one clock edge.
module bus_status_decoder #(
    parameter int STAT_W = bsd_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] data_bus,
    input  logic              sync,
    input  logic              dbin,
    input  logic              wr_n,
    input  logic              hlda,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              int_ack,
    output logic              halted,
    output logic              stack_acc,
    output logic              op_fetch
);
    logic [STAT_W-1:0] status_q;
    logic              valid_q;
    bsd_pkg::strobe_t  strobe;
    bsd_pkg::indic_t   indic;

    bsd_status_capture #(.STAT_W(STAT_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (data_bus),
        .sync     (sync),
        .status_q (status_q),
        .valid_q  (valid_q)
    );

    bsd_strobe_decode #(.STAT_W(STAT_W)) u_decode (
        .status_i (status_q),
        .valid_i  (valid_q),
        .rd_i     (dbin),
        .wr_n_i   (wr_n),
        .hold_i   (hlda),
        .strobe_o (strobe),
        .indic_o  (indic)
    );

    // Unpack the bundles onto the ports.
    always_comb begin
        mem_rd    = strobe.mem_rd;
        mem_wr    = strobe.mem_wr;
        io_rd     = strobe.io_rd;
        io_wr     = strobe.io_wr;
        int_ack   = strobe.int_ack;
        halted    = indic.halted;
        stack_acc = indic.stack_acc;
        op_fetch  = indic.op_fetch;
    end
endmodule

// File: rtl/bsd_checker.sv
// Module: port-level properties of the status decoder, bound to the top.
module bsd_checker (
    input logic clk,
    input logic rst_n,
    input logic sync,
    input logic dbin,
    input logic wr_n,
    input logic hlda,
    input logic mem_rd,
    input logic mem_wr,
    input logic io_rd,
    input logic io_wr,
    input logic int_ack,
    input logic halted,
    input logic stack_acc,
    input logic op_fetch
);
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> !(mem_rd || mem_wr || io_rd || io_wr || int_ack)); // R8
    AST_READ_NEEDS_DBIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || io_rd || int_ack) |-> dbin); // R3
    AST_WRITE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || io_wr) |-> !wr_n); // R6
    AST_WRITE_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, io_wr})); // R7
    AST_INDIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sync)) |-> $stable({halted, stack_acc, op_fetch})); // R1
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> !(mem_rd || mem_wr || io_rd || io_wr || int_ack
                              || halted || stack_acc || op_fetch)); // R2
endmodule

bind bus_status_decoder bsd_checker u_bsd_checker (
    .clk(clk), .rst_n(rst_n), .sync(sync), .dbin(dbin), .wr_n(wr_n),
    .hlda(hlda), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .int_ack(int_ack), .halted(halted),
    .stack_acc(stack_acc), .op_fetch(op_fetch)
);

// File: tb/bus_status_decoder_bench.sv
module bus_status_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_bus = 8'h00;
    logic       sync = 1'b0, dbin = 1'b0, wr_n = 1'b1, hlda = 1'b0;
    logic mem_rd, mem_wr, io_rd, io_wr, int_ack, halted, stack_acc, op_fetch;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_status_decoder u_bus_status_decoder (
        .clk(clk), .rst_n(rst_n), .data_bus(data_bus), .sync(sync),
        .dbin(dbin), .wr_n(wr_n), .hlda(hlda), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .int_ack(int_ack),
        .halted(halted), .stack_acc(stack_acc), .op_fetch(op_fetch)
    );

    // Output order: mem_rd mem_wr io_rd io_wr int_ack halted stack_acc op_fetch
    function automatic logic [7:0] outs();
        return {mem_rd, mem_wr, io_rd, io_wr, int_ack, halted, stack_acc, op_fetch};
    endfunction

    task automatic check(input int req, input logic [7:0] exp, input string what);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL R%0d %s: outputs %b expected %b", req, what, outs(), exp);
        end
    endtask

    task automatic capture(input logic [7:0] st);
        @(negedge clk); data_bus = st; sync = 1'b1;
        @(negedge clk); sync = 1'b0; data_bus = ~st; // junk after sync (R10)
    endtask

    // {status, dbin, wr_n, hlda, expected outputs, requirement}
    typedef struct packed {
        logic [7:0] st; logic rd; logic wn; logic hd; logic [7:0] exp; logic [7:0] req;
    } vec_t;
    localparam vec_t VECS [14] = '{
        '{8'hA2, 1'b1, 1'b1, 1'b0, 8'b1000_0001, 8'd3},  // R3 fetch, R9 op_fetch
        '{8'h82, 1'b1, 1'b1, 1'b0, 8'b1000_0000, 8'd3},  // R3 memory read
        '{8'h00, 1'b0, 1'b0, 1'b0, 8'b0100_0000, 8'd7},  // R7 memory write
        '{8'h10, 1'b0, 1'b0, 1'b0, 8'b0001_0000, 8'd6},  // R6 port write
        '{8'h42, 1'b1, 1'b1, 1'b0, 8'b0010_0000, 8'd4},  // R4 port read
        '{8'h23, 1'b1, 1'b1, 1'b0, 8'b0000_1001, 8'd5},  // R5 interrupt ack fetch
        '{8'h86, 1'b1, 1'b1, 1'b0, 8'b1000_0010, 8'd9},  // R9 stack read
        '{8'h04, 1'b0, 1'b0, 1'b0, 8'b0100_0010, 8'd9},  // R9 stack write
        '{8'h8A, 1'b0, 1'b1, 1'b0, 8'b0000_0100, 8'd9},  // R9 halted
        '{8'h82, 1'b1, 1'b1, 1'b1, 8'b0000_0000, 8'd8},  // R8 hold blocks read
        '{8'h04, 1'b0, 1'b0, 1'b1, 8'b0000_0010, 8'd8},  // R8 hold blocks write
        '{8'h82, 1'b0, 1'b0, 1'b0, 8'b0000_0000, 8'd11}, // R11 write in read cycle
        '{8'h42, 1'b0, 1'b1, 1'b0, 8'b0000_0000, 8'd4},  // R4 no strobe, no read
        '{8'h10, 1'b0, 1'b1, 1'b0, 8'b0000_0000, 8'd6}   // R6 no strobe, no write
    };

    initial begin
        // R2: reset state and quiet outputs before the first sync
        dbin = 1'b1; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        check(2, 8'h00, "in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2 check(2, 8'h00, "after reset, no sync yet");
        dbin = 1'b0; wr_n = 1'b1;

        foreach (VECS[i]) begin
            capture(VECS[i].st);
            dbin = VECS[i].rd; wr_n = VECS[i].wn; hlda = VECS[i].hd;
            #2 check(int'(VECS[i].req), VECS[i].exp, $sformatf("vector %0d", i));
            @(negedge clk); dbin = 1'b0; wr_n = 1'b1; hlda = 1'b0;
        end

        // R1 and R10: held status survives bus changes while sync is low
        capture(8'h86);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); data_bus = 8'h10 + 8'(k);
        end
        dbin = 1'b1;
        #2 check(1, 8'b1000_0010, "status held over cycles");
        check(10, 8'b1000_0010, "bus junk ignored");
        dbin = 1'b0; wr_n = 1'b0;
        #1 check(10, 8'b0000_0010, "no write from junk port bit");
        wr_n = 1'b1;

        // R1: a new sync replaces the held value
        capture(8'h10);
        wr_n = 1'b0;
        #2 check(1, 8'b0001_0000, "reloaded on next sync");
        wr_n = 1'b1;

        // R2: reset again clears the capture
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        #2 check(2, 8'h00, "cleared by second reset");
        wr_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL R1 watchdog: outputs %b expected completion", outs());
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule